// File: doc/BRIEF.md
# DDR Edge-Split Self-Test Checksum Accumulator

This block accumulates a self-test checksum over a double-data-rate sample stream. Every core clock carries two words: one captured on the rising edge (the I path) and one captured on the falling edge (the Q path). Each path has its own independent 16-bit running sum. Both sums wrap modulo 2^16.

Software drives the block through a byte-wide control register. A two-write clear sequence zeroes both sums and both snapshots. One control value starts accumulation. A further value latches the two running sums into byte-readable snapshot registers.

A typical test runs in this order:
1. Clear the sums.
2. Enable accumulation.
3. Stream a known stimulus.
4. Follow it with zeros, which leave the sums unchanged.
5. Issue the latch.
6. Read the four snapshot bytes and compare them against a golden checksum.

Top module: `bist_ddr_checksum`

## Requirements
- R1: After reset the control register reads 0x00, and all four snapshot bytes read 0x00.
- R2: Writing 0x20 and then 0x00 to the control register (address 0x1A) zeroes both running sums and both snapshots. Writing 0x20 alone clears nothing.
- R3: While the control register has bit 7 set and bit 6 clear (for example 0x80), each clock edge adds rise_word_i to the rising sum and fall_word_i to the falling sum. The two sums are independent of each other.
- R4: While bit 7 is clear, or bit 6 is set, the input words do not change either sum.
- R5: A control write with bits 7 and 6 both set (0xC0) copies both running sums, as they stood before that edge, into the snapshot registers.
- R6: Read map: 0x1A returns the control value; 0x1B and 0x1C return the low and high bytes of the rising snapshot; 0x1D and 0x1E return the low and high bytes of the falling snapshot; any other address returns 0x00. Writes to addresses other than 0x1A have no effect.
- R7: Each sum wraps modulo 2^16 on overflow.
- R8: Zero-valued input words leave the sums unchanged while accumulation is enabled.
- R9: The snapshots hold their value until the next latch write or clear sequence.
- R10: An identical input sequence after a clear always produces identical snapshot values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; one rising/falling word pair per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for writes and reads |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for reg_addr_i |
| rise_word_i | input | 16 | Word captured on the rising data edge |
| fall_word_i | input | 16 | Word captured on the falling data edge |

## Verification
The assertions assume two things about the inputs:
- Control writes arrive as single-cycle strobes.
- The input words are stable across the sampling edge.

The stimulus meets both conditions: it changes every input only at the falling clock edge, and it never asserts the write strobe for more than one cycle. The stimulus also holds the input words at zero around every control write, except in the directed cases that probe disabled, read-mode and zero-input behaviour. This keeps each expected checksum a pure function of the words streamed while accumulation is enabled.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 8'h1A;
  localparam logic [REG_AW-1:0] SNAP_BASE = 8'h1B;
  localparam int EN_BIT  = 7;
  localparam int RD_BIT  = 6;
  localparam int CLR_BIT = 5;
  localparam int NUM_EDGES = 2;
endpackage

// File: rtl/bist_ctrl_decode.sv
module bist_ctrl_decode
  import bist_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] ctrl_o,
  output logic              acc_en_o,
  output logic              latch_o,
  output logic              clear_o
);
  logic [REG_DW-1:0] ctrl_q;
  logic              hit;

  assign hit      = reg_wr_i && (reg_addr_i == CTRL_ADDR);
  // clear on the 0x00 write that follows a value with the clear bit
  assign clear_o  = hit && (reg_wdata_i == '0) && ctrl_q[CLR_BIT];
  assign latch_o  = hit && reg_wdata_i[EN_BIT] && reg_wdata_i[RD_BIT];
  assign acc_en_o = ctrl_q[EN_BIT] && !ctrl_q[RD_BIT];
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ctrl_q <= '0;
    else if (hit) ctrl_q <= reg_wdata_i;
  end

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(ctrl_q));
endmodule

// File: rtl/bist_edge_acc.sv
module bist_edge_acc #(
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             latch_i,
  input  logic [SUM_W-1:0] word_i,
  output logic [SUM_W-1:0] snap_o
);
  logic [SUM_W-1:0] sum_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      snap_q <= '0;
    end else if (clear_i) begin
      sum_q  <= '0;
      snap_q <= '0;
    end else begin
      if (en_i)    sum_q  <= sum_q + word_i;  // wraps modulo 2^SUM_W
      if (latch_i) snap_q <= sum_q;
    end
  end

  assign snap_o = snap_q;

  // R2
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_q == '0) && (snap_q == '0));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clear_i |=> $stable(sum_q));
  // R8
  zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clear_i && (word_i == '0) |=> $stable(sum_q));
  // R5
  latch_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && !clear_i |=> snap_q == $past(sum_q));
  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i && !clear_i |=> $stable(snap_q));
endmodule

// File: rtl/bist_readback.sv
module bist_readback
  import bist_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [REG_DW-1:0]                 ctrl_i,
  input  logic [NUM_EDGES-1:0][SUM_W-1:0]   snap_i,
  output logic [REG_DW-1:0]                 rdata_o
);
  localparam int BYTES = SUM_W / REG_DW;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = ctrl_i;
    for (int e = 0; e < NUM_EDGES; e++)
      for (int b = 0; b < BYTES; b++)
        if (addr_i == SNAP_BASE + REG_AW'(e*BYTES + b))
          rdata_o = snap_i[e][b*REG_DW +: REG_DW];
  end
endmodule

// File: rtl/bist_ddr_checksum.sv
module bist_ddr_checksum
  import bist_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic [SUM_W-1:0]  rise_word_i,
  input  logic [SUM_W-1:0]  fall_word_i
);
  logic [REG_DW-1:0]               ctrl;
  logic                            acc_en, latch, clear;
  logic [NUM_EDGES-1:0][SUM_W-1:0] words, snaps;

  assign words[0] = rise_word_i;
  assign words[1] = fall_word_i;

  bist_ctrl_decode u_dec (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .ctrl_o(ctrl), .acc_en_o(acc_en), .latch_o(latch), .clear_o(clear)
  );

  for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
    bist_edge_acc #(.SUM_W(SUM_W)) u_acc (
      .clk_i, .rst_ni, .clear_i(clear), .en_i(acc_en), .latch_i(latch),
      .word_i(words[e]), .snap_o(snaps[e])
    );
  end

  bist_readback #(.SUM_W(SUM_W)) u_rb (
    .addr_i(reg_addr_i), .ctrl_i(ctrl), .snap_i(snaps), .rdata_o(reg_rdata_o)
  );
endmodule

// File: tb/bist_ddr_checksum_test.sv
module bist_ddr_checksum_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] rise = '0, fall = '0;
  int checks = 0, errors = 0;
  logic [15:0] exp_r, exp_f, first_r, first_f;

  localparam logic [31:0] VEC [8] = '{
    32'h0001_0002, 32'h1234_8765, 32'hFFFF_0001, 32'h0000_4000,
    32'hA5A5_5A5A, 32'h7FFF_7FFF, 32'h0100_00FF, 32'hDEAD_BEEF};

  always #2.5 clk = ~clk;

  bist_ddr_checksum uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rise_word_i(rise), .fall_word_i(fall));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [7:0] lo_a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(lo_a, lo); rd(lo_a + 8'd1, hi); v = {hi, lo};
  endtask

  task automatic feed(input logic [15:0] r, input logic [15:0] f);
    @(negedge clk); rise = r; fall = f;
    @(negedge clk); rise = '0; fall = '0;
  endtask

  task automatic clear_seq();
    wr_reg(8'h1A, 8'h20); wr_reg(8'h1A, 8'h00);
  endtask

  task automatic check_snaps(input string req, input logic [15:0] er, input logic [15:0] ef);
    logic [15:0] v;
    rd16(8'h1B, v); check(req, v, er);
    rd16(8'h1D, v); check(req, v, ef);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    #12 rst_n = 1'b1;
    // R1 reset state
    rd(8'h1A, b); check("R1 ctrl", 16'(b), 16'h0);
    check_snaps("R1 snap", 16'h0, 16'h0);

    // R3 R5 R7 table walk: feed one pair, latch, check, re-enable
    exp_r = '0; exp_f = '0;
    wr_reg(8'h1A, 8'h80);
    for (int i = 0; i < 8; i++) begin
      feed(VEC[i][31:16], VEC[i][15:0]);
      exp_r += VEC[i][31:16]; exp_f += VEC[i][15:0];
      wr_reg(8'h1A, 8'hC0);
      check_snaps("R3 R5 R7 table", exp_r, exp_f);
      wr_reg(8'h1A, 8'h80);
    end
    first_r = exp_r; first_f = exp_f;

    // R8 zero stream keeps sums
    for (int i = 0; i < 20; i++) feed(16'h0, 16'h0);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R8 zeros", exp_r, exp_f);

    // R4 read bit set: data ignored
    feed(16'h1111, 16'h2222);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R4 read-mode", exp_r, exp_f);
    // R4 enable clear: data ignored
    wr_reg(8'h1A, 8'h00);
    feed(16'h3333, 16'h4444);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R4 disabled", exp_r, exp_f);

    // R9 snapshot holds while sums move
    wr_reg(8'h1A, 8'h80);
    feed(16'h0010, 16'h0020);
    check_snaps("R9 hold", exp_r, exp_f);

    // R6 other address write ignored, other address read zero
    wr_reg(8'h15, 8'hC0);
    check_snaps("R6 stray write", exp_r, exp_f);
    rd(8'h1F, b); check("R6 unmapped", 16'(b), 16'h0);
    rd(8'h1A, b); check("R6 ctrl read", 16'(b), 16'h80);

    // R2 0x20 alone does not clear
    wr_reg(8'h1A, 8'h20);
    wr_reg(8'h1A, 8'hC0);
    exp_r += 16'h0010; exp_f += 16'h0020;
    check_snaps("R2 partial", exp_r, exp_f);
    // R2 full sequence clears sums and snapshots
    clear_seq();
    check_snaps("R2 clear", 16'h0, 16'h0);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R2 sums zero", 16'h0, 16'h0);

    // R7 wrap
    clear_seq();
    wr_reg(8'h1A, 8'h80);
    feed(16'hFFFF, 16'h8000);
    feed(16'hFFFF, 16'h8000);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R7 wrap", 16'hFFFE, 16'h0000);

    // R3 independence: only rising path non-zero
    clear_seq();
    wr_reg(8'h1A, 8'h80);
    feed(16'h0ABC, 16'h0000);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R3 independent", 16'h0ABC, 16'h0000);

    // R10 repeat table after clear
    clear_seq();
    wr_reg(8'h1A, 8'h80);
    for (int i = 0; i < 8; i++) feed(VEC[i][31:16], VEC[i][15:0]);
    wr_reg(8'h1A, 8'hC0);
    check_snaps("R10 repeat", first_r, first_f);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_snaps("R1 re-reset", 16'h0, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule